// File: doc/BRIEF.md
# Program Counter with Latched Upper Bytes

This block holds the fetch address of a processor as a 21-bit byte address that always points at an even byte. Each advance request steps the address on to the next two-byte instruction word. A jump or call target from the decoder replaces the whole address in one cycle.

Software reaches only the low byte of the address directly. The middle byte and the 5-bit top field sit behind two latch registers, which software can read and write freely. A write of the low byte is the only way the latched values reach the counter: the new low byte and both latches go into the address together. A read of the low byte does the reverse. It snapshots the current middle byte and top field into the latches, so that computed-offset code can work with the full address.

Top module: `prog_counter_latched`

## Requirements
- R1: After reset, `pc_o`, `hi_shadow_o` and `up_shadow_o` are all zero.
- R2: With only `adv_i` asserted, `pc_o` one cycle later equals the previous `pc_o` plus 2.
- R3: Bit 0 of `pc_o` is always 0. Bit 0 of a written low byte or of a loaded target is discarded.
- R4: With `lo_wr_i` asserted and no load, the next `pc_o` is `{upper latch, high latch, lo_wdata_i with bit 0 cleared}`. The latch values used are those held before the clock edge.
- R5: `lo_rdata_o` always shows `pc_o[7:0]`. With `lo_rd_i` asserted, the latches take `pc_o[15:8]` and `pc_o[20:16]` as they were before the edge, and `pc_o` is not changed by the read.
- R6: With `load_i` asserted, the next `pc_o` is `load_addr_i` with bit 0 cleared. Neither latch changes because of the load.
- R7: `hi_shadow_wr_i` stores all 8 bits of `hi_shadow_wdata_i`. `up_shadow_wr_i` stores bits 4:0 of `up_shadow_wdata_i` and ignores bits 7:5. Bits 7:5 of `up_shadow_o` always read 0.
- R8: The priority on the counter is load, then low-byte write, then advance. With none of them requested, `pc_o` holds its value.
- R9: When a latch write and `lo_rd_i` occur in the same cycle, the explicit write sets that latch.
- R10: An advance from 0x1FFFFE wraps `pc_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Step to the next instruction word |
| load_i | input | 1 | Load a jump or call target |
| load_addr_i | input | 21 | Target address |
| lo_wr_i | input | 1 | Low-byte write strobe |
| lo_wdata_i | input | 8 | Low-byte write data |
| lo_rd_i | input | 1 | Low-byte read strobe (captures upper bytes) |
| lo_rdata_o | output | 8 | Low byte of the address |
| hi_shadow_wr_i | input | 1 | High latch write strobe |
| hi_shadow_wdata_i | input | 8 | High latch write data |
| hi_shadow_o | output | 8 | High latch contents |
| up_shadow_wr_i | input | 1 | Upper latch write strobe |
| up_shadow_wdata_i | input | 8 | Upper latch write data (bits 4:0 used) |
| up_shadow_o | output | 8 | Upper latch contents, bits 7:5 zero |
| pc_o | output | 21 | Program counter |

## Verification
The bench builds the block with its default widths: a 21-bit counter, an 8-bit low byte, an 8-bit high byte and a 5-bit upper field. At these widths the top-of-range wrap at 0x1FFFFE can be reached with one load and one advance. The 5-bit upper field also sits inside an 8-bit port, so writes to the unused bits 7:5 can be seen to have no effect. A deterministic pseudo-random phase mixes every strobe in the same cycles. That exercises the priority rules and the read-versus-write latch conflicts against a model in the bench.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADV  = 2'd1,
    OP_LOWR = 2'd2,
    OP_LOAD = 2'd3
  } pcx_op_e;

  // Clear the alignment bit of any address-like value.
  function automatic logic [31:0] pcx_align(input logic [31:0] v);
    return {v[31:1], 1'b0};
  endfunction

  // Next sequential word address, wrapped to w bits (w < 32).
  function automatic logic [31:0] pcx_step(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (32'h1 << w) - 32'h1;
    return (v + 32'd2) & mask;
  endfunction

endpackage

// File: rtl/pcx_arbiter.sv
module pcx_arbiter
  import pcx_pkg::*;
(
  input  logic    load_i,
  input  logic    lowr_i,
  input  logic    adv_i,
  output pcx_op_e op_o
);
  always_comb begin
    if (load_i)      op_o = OP_LOAD;
    else if (lowr_i) op_o = OP_LOWR;
    else if (adv_i)  op_o = OP_ADV;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcx_core.sv
module pcx_core
  import pcx_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pcx_op_e         op_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic [PC_W-1:0] lowr_val_i,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] PC_TOP = {{(PC_W-1){1'b1}}, 1'b0};

  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD: pc_d = PC_W'(pcx_align(32'(load_val_i)));
      OP_LOWR: pc_d = PC_W'(pcx_align(32'(lowr_val_i)));
      OP_ADV:  pc_d = PC_W'(pcx_step(32'(pc_q), PC_W));
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assert_step_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADV && pc_q != PC_TOP) |=> (pc_q - $past(pc_q)) == PC_W'(2));

  assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(pc_q));

  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADV && pc_q == PC_TOP) |=> pc_q == '0);
endmodule

// File: rtl/pcx_shadow.sv
module pcx_shadow #(
  parameter int HI_W   = 8,
  parameter int UP_W   = 5,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr_i,
  input  logic [PORT_W-1:0] hi_wdata_i,
  input  logic              up_wr_i,
  input  logic [PORT_W-1:0] up_wdata_i,
  input  logic              capture_i,
  input  logic [HI_W-1:0]   cap_hi_i,
  input  logic [UP_W-1:0]   cap_up_i,
  output logic [HI_W-1:0]   hi_q,
  output logic [UP_W-1:0]   up_q
);
  logic unused_up_bits;
  assign unused_up_bits = ^up_wdata_i[PORT_W-1:UP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      up_q <= '0;
    end else begin
      if (hi_wr_i)        hi_q <= HI_W'(hi_wdata_i);
      else if (capture_i) hi_q <= cap_hi_i;
      if (up_wr_i)        up_q <= up_wdata_i[UP_W-1:0];
      else if (capture_i) up_q <= cap_up_i;
    end
  end

  assert_latch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr_i && !up_wr_i && !capture_i) |=> ($stable(hi_q) && $stable(up_q)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr_i && capture_i) |=> hi_q == $past(hi_wdata_i[HI_W-1:0]));
endmodule

// File: rtl/prog_counter_latched.sv
module prog_counter_latched
  import pcx_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int LO_W   = 8,
  parameter int HI_W   = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [PC_W-1:0]   load_addr_i,
  input  logic              lo_wr_i,
  input  logic [LO_W-1:0]   lo_wdata_i,
  input  logic              lo_rd_i,
  output logic [LO_W-1:0]   lo_rdata_o,
  input  logic              hi_shadow_wr_i,
  input  logic [PORT_W-1:0] hi_shadow_wdata_i,
  output logic [PORT_W-1:0] hi_shadow_o,
  input  logic              up_shadow_wr_i,
  input  logic [PORT_W-1:0] up_shadow_wdata_i,
  output logic [PORT_W-1:0] up_shadow_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int UP_W  = PC_W - LO_W - HI_W;
  localparam int HI_LO = LO_W;
  localparam int UP_LO = LO_W + HI_W;

  // Named events for the assertions.
  logic ev_load, ev_lowr, ev_adv, ev_capture;
  pcx_op_e op;
  logic [HI_W-1:0] hi_q;
  logic [UP_W-1:0] up_q;
  logic [PC_W-1:0] lowr_val;

  assign ev_load    = load_i;
  assign ev_lowr    = lo_wr_i;
  assign ev_adv     = adv_i;
  assign ev_capture = lo_rd_i;
  assign lowr_val   = {up_q, hi_q, lo_wdata_i};

  pcx_arbiter u_arb (
    .load_i (ev_load),
    .lowr_i (ev_lowr),
    .adv_i  (ev_adv),
    .op_o   (op)
  );

  pcx_core #(.PC_W(PC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .load_val_i (load_addr_i),
    .lowr_val_i (lowr_val),
    .pc_q       (pc_o)
  );

  pcx_shadow #(.HI_W(HI_W), .UP_W(UP_W), .PORT_W(PORT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_wr_i    (hi_shadow_wr_i),
    .hi_wdata_i (hi_shadow_wdata_i),
    .up_wr_i    (up_shadow_wr_i),
    .up_wdata_i (up_shadow_wdata_i),
    .capture_i  (ev_capture),
    .cap_hi_i   (pc_o[UP_LO-1:HI_LO]),
    .cap_up_i   (pc_o[PC_W-1:UP_LO]),
    .hi_q       (hi_q),
    .up_q       (up_q)
  );

  assign lo_rdata_o  = pc_o[LO_W-1:0];
  assign hi_shadow_o = PORT_W'(hi_q);
  assign up_shadow_o = PORT_W'(up_q);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc_o == '0 && hi_q == '0 && up_q == '0));

  assert_lowwr_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lowr && !ev_load) |=>
      pc_o == {$past(up_q), $past(hi_q), $past(lo_wdata_i[LO_W-1:1]), 1'b0});

  assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !hi_shadow_wr_i) |=> hi_q == $past(pc_o[UP_LO-1:HI_LO]));

  assert_read_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !ev_load && !ev_lowr && !ev_adv) |=> $stable(pc_o));

  assert_load_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> pc_o[PC_W-1:1] == $past(load_addr_i[PC_W-1:1]));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_shadow_o >> UP_W) == '0);
endmodule

// File: tb/prog_counter_latched_tb_top.sv
`timescale 1ns/1ps
module prog_counter_latched_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        adv_i = 0, load_i = 0, lo_wr_i = 0, lo_rd_i = 0;
  logic        hi_shadow_wr_i = 0, up_shadow_wr_i = 0;
  logic [20:0] load_addr_i = '0, pc_o;
  logic [7:0]  lo_wdata_i = '0, hi_shadow_wdata_i = '0, up_shadow_wdata_i = '0;
  logic [7:0]  lo_rdata_o, hi_shadow_o, up_shadow_o;

  prog_counter_latched dut_i (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i),
    .lo_rd_i(lo_rd_i), .lo_rdata_o(lo_rdata_o),
    .hi_shadow_wr_i(hi_shadow_wr_i), .hi_shadow_wdata_i(hi_shadow_wdata_i),
    .hi_shadow_o(hi_shadow_o), .up_shadow_wr_i(up_shadow_wr_i),
    .up_shadow_wdata_i(up_shadow_wdata_i), .up_shadow_o(up_shadow_o),
    .pc_o(pc_o)
  );

  typedef struct {
    string       tag;
    logic [20:0] pc;
    logic [7:0]  hi;
    logic [7:0]  up;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference model state
  logic [20:0] m_pc = '0;
  logic [7:0]  m_hi = '0;
  logic [4:0]  m_up = '0;

  function automatic void compare(exp_t e);
    vectors++;
    if (pc_o !== e.pc || hi_shadow_o !== e.hi || up_shadow_o !== e.up ||
        lo_rdata_o !== e.pc[7:0]) begin
      miscompares++;
      $display("FAIL %s: pc=%h hi=%h up=%h lo=%h expected pc=%h hi=%h up=%h lo=%h",
               e.tag, pc_o, hi_shadow_o, up_shadow_o, lo_rdata_o,
               e.pc, e.hi, e.up, e.pc[7:0]);
    end
  endfunction

  // Monitor: one expected item per driven cycle, checked after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  task automatic step(input string tag, input bit ld, input logic [20:0] tgt,
                      input bit lw, input logic [7:0] wd, input bit rd,
                      input bit adv, input bit hw, input logic [7:0] hwd,
                      input bit uw, input logic [7:0] uwd);
    logic [20:0] n_pc;
    logic [7:0]  n_hi;
    logic [4:0]  n_up;
    exp_t e;
    @(negedge clk);
    load_i = ld; load_addr_i = tgt; lo_wr_i = lw; lo_wdata_i = wd;
    lo_rd_i = rd; adv_i = adv; hi_shadow_wr_i = hw; hi_shadow_wdata_i = hwd;
    up_shadow_wr_i = uw; up_shadow_wdata_i = uwd;
    // Priority load > low write > advance; bit 0 always dropped.
    if (ld)       n_pc = tgt & ~21'd1;
    else if (lw)  n_pc = {m_up, m_hi, wd & 8'hFE};
    else if (adv) n_pc = m_pc + 21'd2;
    else          n_pc = m_pc;
    n_hi = hw ? hwd : (rd ? m_pc[15:8] : m_hi);
    n_up = uw ? uwd[4:0] : (rd ? m_pc[20:16] : m_up);
    m_pc = n_pc; m_hi = n_hi; m_up = n_up;
    e.tag = tag; e.pc = m_pc; e.hi = m_hi; e.up = {3'b000, m_up};
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, 0, '0, 0, 0, 0, '0, 0, '0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, checked directly
    begin
      exp_t e; e.tag = "R1 reset"; e.pc = '0; e.hi = '0; e.up = '0;
      compare(e);
    end
    // R2: sequential advance
    step("R2 advance", 0, '0, 0, '0, 0, 1, 0, '0, 0, '0);
    step("R2 advance", 0, '0, 0, '0, 0, 1, 0, '0, 0, '0);
    step("R2 advance", 0, '0, 0, '0, 0, 1, 0, '0, 0, '0);
    // R5: read captures upper bytes (zero here), pc unchanged
    step("R5 read capture", 0, '0, 0, '0, 1, 0, 0, '0, 0, '0);
    // R7: latch writes, upper bits 7:5 ignored
    step("R7 latch write", 0, '0, 0, '0, 0, 0, 1, 8'hAB, 1, 8'hFF);
    step("R7 upper mask", 0, '0, 0, '0, 0, 0, 0, '0, 1, 8'hE3);
    step("R7 latch write", 0, '0, 0, '0, 0, 0, 0, '0, 1, 8'h1F);
    // R4: low write transfers latches, R3 bit 0 dropped
    step("R4 low write", 0, '0, 1, 8'h35, 0, 0, 0, '0, 0, '0);
    // R6/R3: direct load, odd target, latches untouched
    step("R6 load", 0, '0, 0, '0, 0, 0, 0, '0, 0, '0);
    step("R6 load R3 odd", 1, 21'h012345, 0, '0, 0, 0, 0, '0, 0, '0);
    idle("R6 latches kept");
    // R5: capture of nonzero upper bytes
    step("R5 read capture", 0, '0, 0, '0, 1, 0, 0, '0, 0, '0);
    // R8: priorities
    step("R8 load over adv", 1, 21'h000100, 0, '0, 0, 1, 0, '0, 0, '0);
    step("R8 lowwr over adv", 0, '0, 1, 8'h81, 0, 1, 0, '0, 0, '0);
    step("R8 load over lowwr", 1, 21'h0ABCDE, 1, 8'h10, 0, 0, 0, '0, 0, '0);
    idle("R8 hold");
    idle("R8 hold");
    // R10: wrap at top of range
    step("R10 load top", 1, 21'h1FFFFF, 0, '0, 0, 0, 0, '0, 0, '0);
    step("R10 wrap", 0, '0, 0, '0, 0, 1, 0, '0, 0, '0);
    // R9: explicit latch write beats capture
    step("R6 load", 1, 21'h1F3C00, 0, '0, 0, 0, 0, '0, 0, '0);
    step("R9 write vs read", 0, '0, 0, '0, 1, 0, 1, 8'h55, 0, '0);
    step("R9 upper write vs read", 0, '0, 0, '0, 1, 0, 0, '0, 1, 8'h02);
    step("R4 low write new latches", 0, '0, 1, 8'hFF, 0, 0, 0, '0, 0, '0);
    step("R5 read with lowwr", 0, '0, 1, 8'h40, 1, 0, 0, '0, 0, '0);
    idle("R5 after");
    // Mixed pseudo-random traffic (R8 priority and all rules)
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R8 mixed", lfsr[0] & lfsr[5], {lfsr[20:1], lfsr[9]}, lfsr[1] & lfsr[6],
           lfsr[15:8], lfsr[2], lfsr[3], lfsr[4] & lfsr[7], lfsr[23:16],
           lfsr[10] & lfsr[11], lfsr[31:24]);
    end
    @(negedge clk);
    load_i = 0; lo_wr_i = 0; lo_rd_i = 0; adv_i = 0;
    hi_shadow_wr_i = 0; up_shadow_wr_i = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule